// File: doc/BRIEF.md
# Multi-Queue Command Dispatcher

The dispatcher accepts a single stream of commands in global issue order. Each command carries a queue number and a kind. The kind is either a compute job or a copy job, and a copy job moves data either host-to-device or device-to-host. The dispatcher holds the commands in a pending window and launches them onto two dispatch ports, one for compute and one for copies. Each launch carries a tag, and the execution side returns that tag when the job finishes.

Three rules decide when a command may launch:

- A command waits until every older command of its own queue has finished and its resource is free.
- Each of the two classes launches strictly in issue order. If the oldest waiting command of a class is held back, every younger command of that class also waits, whatever its queue.
- Queue 0 is a serialising queue. A queue-0 command starts only after all older commands have finished, and nothing younger starts while it is waiting or running.

Finished commands leave the window from its oldest end, at most one per cycle.

Top module: `mq_dispatcher`

## Requirements
- R1: During and directly after reset, neither dispatch port is valid and `cmd_ready_o` is high.
- R2: `cmd_ready_o` is low exactly when PEND_DEPTH commands are held. A command is held from its acceptance until it has finished and every older command has left. At most one finished command leaves per cycle, and it is always the oldest.
- R3: The tag of a command is its acceptance index since reset, modulo PEND_DEPTH. The Nth accepted command, counting from 0, carries tag N mod PEND_DEPTH.
- R4: A command is never launched while an older command of the same queue is waiting, is running, or has a completion still pending.
- R5: At most MAX_COMPUTE compute jobs are in flight. A completion frees its slot from the following cycle.
- R6: At most one host-to-device copy and one device-to-host copy are in flight at any time.
- R7: Compute commands launch in issue order, and copy commands launch in issue order. The oldest waiting command of a class is the only one of that class that may launch in a given cycle. Each command launches exactly once.
- R8: A queue-0 command launches only when no older command is still held and unfinished. While a queue-0 command is unfinished, no younger command launches.
- R9: A compute launch and a copy launch may occur in the same cycle, and they always carry different tags.
- R10: Kind codes are: 0 for compute, 1 for a host-to-device copy, and 2 or 3 for a device-to-host copy. `copy_dir_o` is 0 for host-to-device and 1 for device-to-host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is offered |
| cmd_ready_o | output | 1 | The pending window has space |
| cmd_queue_i | input | $clog2(NUM_QUEUES) | Queue number of the offered command |
| cmd_kind_i | input | 2 | Kind code (see R10) |
| comp_valid_o | output | 1 | Compute launch this cycle |
| comp_tag_o | output | $clog2(PEND_DEPTH) | Tag of the launched compute job |
| copy_valid_o | output | 1 | Copy launch this cycle |
| copy_tag_o | output | $clog2(PEND_DEPTH) | Tag of the launched copy |
| copy_dir_o | output | 1 | Direction of the launched copy |
| comp_done_i | input | 1 | A compute job finished |
| comp_done_tag_i | input | $clog2(PEND_DEPTH) | Tag of the finished compute job |
| copy_done_i | input | 1 | A copy finished |
| copy_done_tag_i | input | $clog2(PEND_DEPTH) | Tag of the finished copy |

## Verification
The bound checker watches four things on every cycle:

- the compute occupancy limit;
- exclusivity of each copy direction;
- distinct tags when both ports launch together;
- no second launch of a tag in the following cycle.

Whether a launch came at the right moment, with the right tag and direction, depends on queue history, class ordering and queue-0 serialisation. Only the bench's cycle-accurate model of the rules can show that. The scenarios also show that the compute limit, both copy directions and dual-port launches are actually reached.

// File: rtl/cqd_pkg.sv
package cqd_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } ent_state_e;

  localparam logic [1:0] KIND_COMP = 2'd0;
endpackage

// File: rtl/cqd_ring.sv
module cqd_ring #(
  parameter int DEPTH = 16,
  parameter int QW    = 3,
  localparam int TW   = $clog2(DEPTH),
  localparam int CW   = TW + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic [QW-1:0]            push_queue_i,
  input  logic [1:0]               push_kind_i,
  output logic                     full_o,
  output logic [CW-1:0]            count_o,
  output logic [TW-1:0]            head_o,
  input  logic [1:0]               run_i,
  input  logic [1:0][TW-1:0]       run_slot_i,
  input  logic [1:0]               done_i,
  input  logic [1:0][TW-1:0]       done_slot_i,
  output logic [DEPTH-1:0][1:0]    age_state_o,
  output logic [DEPTH-1:0][QW-1:0] age_queue_o,
  output logic [DEPTH-1:0][1:0]    age_kind_o,
  output logic [DEPTH-1:0][1:0]    slot_kind_o
);
  import cqd_pkg::*;

  logic [DEPTH-1:0][1:0]    state_q;
  logic [DEPTH-1:0][QW-1:0] queue_q;
  logic [DEPTH-1:0][1:0]    kind_q;
  logic [TW-1:0]            head_q, tail_q;
  logic [CW-1:0]            count_q;
  logic                     pop;

  assign full_o      = (count_q == CW'(DEPTH));
  assign count_o     = count_q;
  assign head_o      = head_q;
  assign slot_kind_o = kind_q;
  assign pop         = (count_q != '0) && (state_q[head_q] == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_i) tail_q <= tail_q + 1'b1;
      if (pop)    head_q <= head_q + 1'b1;
      if (push_i && !pop)      count_q <= count_q + 1'b1;
      else if (!push_i && pop) count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= {DEPTH{ST_DONE}};
      queue_q <= '0;
      kind_q  <= '0;
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (push_i && tail_q == TW'(s)) begin
          state_q[s] <= ST_WAIT;
          queue_q[s] <= push_queue_i;
          kind_q[s]  <= push_kind_i;
        end else begin
          for (int p = 0; p < 2; p++) begin
            if (run_i[p] && run_slot_i[p] == TW'(s))   state_q[s] <= ST_RUN;
          end
          for (int p = 0; p < 2; p++) begin
            if (done_i[p] && done_slot_i[p] == TW'(s)) state_q[s] <= ST_DONE;
          end
        end
      end
    end
  end

  // oldest entry at index 0
  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    logic [TW-1:0] slot;
    assign slot           = head_q + TW'(i);
    assign age_state_o[i] = state_q[slot];
    assign age_queue_o[i] = queue_q[slot];
    assign age_kind_o[i]  = kind_q[slot];
  end
endmodule

// File: rtl/cqd_pick.sv
module cqd_pick #(
  parameter int DEPTH   = 16,
  parameter int NQ      = 8,
  parameter bit IS_COPY = 1'b0,
  localparam int QW     = $clog2(NQ),
  localparam int TW     = $clog2(DEPTH),
  localparam int CW     = TW + 1
) (
  input  logic [CW-1:0]            count_i,
  input  logic [DEPTH-1:0][1:0]    age_state_i,
  input  logic [DEPTH-1:0][QW-1:0] age_queue_i,
  input  logic [DEPTH-1:0][1:0]    age_kind_i,
  input  logic [2:0]               res_ok_i,
  output logic                     fire_o,
  output logic [TW-1:0]            off_o
);
  import cqd_pkg::*;

  logic [NQ-1:0] busy_q;
  logic          any_busy, q0_busy, stop, in_class, res_ok;

  always_comb begin
    busy_q   = '0;
    any_busy = 1'b0;
    q0_busy  = 1'b0;
    stop     = 1'b0;
    fire_o   = 1'b0;
    off_o    = '0;
    in_class = 1'b0;
    res_ok   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < count_i && !stop) begin
        in_class = IS_COPY ? (age_kind_i[i] != KIND_COMP) : (age_kind_i[i] == KIND_COMP);
        // first waiting entry of the class is its head; nothing behind it may pass
        if (age_state_i[i] == ST_WAIT && in_class) begin
          stop   = 1'b1;
          off_o  = TW'(i);
          res_ok = (age_kind_i[i] == KIND_COMP) ? res_ok_i[0] :
                   age_kind_i[i][1]             ? res_ok_i[2] : res_ok_i[1];
          fire_o = res_ok && !busy_q[age_queue_i[i]] && !q0_busy &&
                   !(age_queue_i[i] == '0 && any_busy);
        end
        if (age_state_i[i] != ST_DONE) begin
          busy_q[age_queue_i[i]] = 1'b1;
          any_busy               = 1'b1;
          if (age_queue_i[i] == '0) q0_busy = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cqd_res.sv
module cqd_res #(
  parameter int MAX_COMPUTE = 16,
  localparam int NW         = $clog2(MAX_COMPUTE + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       comp_fire_i,
  input  logic       comp_done_i,
  input  logic       h2d_fire_i,
  input  logic       h2d_done_i,
  input  logic       d2h_fire_i,
  input  logic       d2h_done_i,
  output logic [2:0] res_ok_o
);
  logic [NW-1:0] comp_cnt_q;
  logic          h2d_busy_q, d2h_busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comp_cnt_q <= '0;
      h2d_busy_q <= 1'b0;
      d2h_busy_q <= 1'b0;
    end else begin
      if (comp_fire_i && !comp_done_i)      comp_cnt_q <= comp_cnt_q + 1'b1;
      else if (!comp_fire_i && comp_done_i) comp_cnt_q <= comp_cnt_q - 1'b1;
      if (h2d_fire_i)      h2d_busy_q <= 1'b1;
      else if (h2d_done_i) h2d_busy_q <= 1'b0;
      if (d2h_fire_i)      d2h_busy_q <= 1'b1;
      else if (d2h_done_i) d2h_busy_q <= 1'b0;
    end
  end

  assign res_ok_o[0] = comp_cnt_q < NW'(MAX_COMPUTE);
  assign res_ok_o[1] = !h2d_busy_q;
  assign res_ok_o[2] = !d2h_busy_q;
endmodule

// File: rtl/mq_dispatcher.sv
module mq_dispatcher #(
  parameter int NUM_QUEUES  = 8,
  parameter int PEND_DEPTH  = 16,
  parameter int MAX_COMPUTE = 16,
  localparam int QW         = $clog2(NUM_QUEUES),
  localparam int TW         = $clog2(PEND_DEPTH),
  localparam int CW         = TW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic [QW-1:0] cmd_queue_i,
  input  logic [1:0]    cmd_kind_i,
  output logic          comp_valid_o,
  output logic [TW-1:0] comp_tag_o,
  output logic          copy_valid_o,
  output logic [TW-1:0] copy_tag_o,
  output logic          copy_dir_o,
  input  logic          comp_done_i,
  input  logic [TW-1:0] comp_done_tag_i,
  input  logic          copy_done_i,
  input  logic [TW-1:0] copy_done_tag_i
);
  logic                          full, push;
  logic [CW-1:0]                 count;
  logic [TW-1:0]                 head;
  logic [PEND_DEPTH-1:0][1:0]    age_state, age_kind, slot_kind;
  logic [PEND_DEPTH-1:0][QW-1:0] age_queue;
  logic [1:0]                    fire;
  logic [1:0][TW-1:0]            off, slot, done_slot;
  logic [1:0]                    done;
  logic [2:0]                    res_ok;
  logic                          done_dir;

  assign cmd_ready_o = !full;
  assign push        = cmd_valid_i && !full;

  cqd_ring #(.DEPTH(PEND_DEPTH), .QW(QW)) i_ring (
    .clk_i, .rst_ni,
    .push_i       (push),
    .push_queue_i (cmd_queue_i),
    .push_kind_i  (cmd_kind_i),
    .full_o       (full),
    .count_o      (count),
    .head_o       (head),
    .run_i        (fire),
    .run_slot_i   (slot),
    .done_i       (done),
    .done_slot_i  (done_slot),
    .age_state_o  (age_state),
    .age_queue_o  (age_queue),
    .age_kind_o   (age_kind),
    .slot_kind_o  (slot_kind)
  );

  // index 0: compute class, index 1: copy class
  for (genvar c = 0; c < 2; c++) begin : g_class
    cqd_pick #(.DEPTH(PEND_DEPTH), .NQ(NUM_QUEUES), .IS_COPY(c == 1)) i_pick (
      .count_i     (count),
      .age_state_i (age_state),
      .age_queue_i (age_queue),
      .age_kind_i  (age_kind),
      .res_ok_i    (res_ok),
      .fire_o      (fire[c]),
      .off_o       (off[c])
    );
    assign slot[c] = head + off[c];
  end

  assign done         = {copy_done_i, comp_done_i};
  assign done_slot    = {copy_done_tag_i, comp_done_tag_i};
  assign done_dir     = slot_kind[copy_done_tag_i][1];

  assign comp_valid_o = fire[0];
  assign comp_tag_o   = slot[0];
  assign copy_valid_o = fire[1];
  assign copy_tag_o   = slot[1];
  assign copy_dir_o   = age_kind[off[1]][1];

  cqd_res #(.MAX_COMPUTE(MAX_COMPUTE)) i_res (
    .clk_i, .rst_ni,
    .comp_fire_i (fire[0]),
    .comp_done_i (comp_done_i),
    .h2d_fire_i  (fire[1] && !copy_dir_o),
    .h2d_done_i  (copy_done_i && !done_dir),
    .d2h_fire_i  (fire[1] && copy_dir_o),
    .d2h_done_i  (copy_done_i && done_dir),
    .res_ok_o    (res_ok)
  );
endmodule

// File: rtl/cqd_chk.sv
module cqd_chk #(
  parameter int MAX_COMPUTE = 16,
  parameter int TW          = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          comp_valid_o,
  input logic [TW-1:0] comp_tag_o,
  input logic          copy_valid_o,
  input logic [TW-1:0] copy_tag_o,
  input logic          copy_dir_o,
  input logic          comp_done_i,
  input logic          copy_done_i,
  input logic [TW-1:0] copy_done_tag_i
);
  logic [7:0]    comp_cnt;
  logic          h2d_busy, d2h_busy;
  logic [TW-1:0] h2d_tag, d2h_tag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      comp_cnt <= '0;
      h2d_busy <= 1'b0;
      d2h_busy <= 1'b0;
      h2d_tag  <= '0;
      d2h_tag  <= '0;
    end else begin
      comp_cnt <= comp_cnt + {7'd0, comp_valid_o} - {7'd0, comp_done_i};
      if (copy_valid_o && !copy_dir_o) begin
        h2d_busy <= 1'b1;
        h2d_tag  <= copy_tag_o;
      end else if (copy_done_i && h2d_busy && copy_done_tag_i == h2d_tag) begin
        h2d_busy <= 1'b0;
      end
      if (copy_valid_o && copy_dir_o) begin
        d2h_busy <= 1'b1;
        d2h_tag  <= copy_tag_o;
      end else if (copy_done_i && d2h_busy && copy_done_tag_i == d2h_tag) begin
        d2h_busy <= 1'b0;
      end
    end
  end

  // R5
  comp_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_valid_o |-> comp_cnt < 8'(MAX_COMPUTE));

  // R6
  h2d_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_valid_o && !copy_dir_o) |-> !h2d_busy);

  // R6
  d2h_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_valid_o && copy_dir_o) |-> !d2h_busy);

  // R9
  dual_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comp_valid_o && copy_valid_o) |-> comp_tag_o != copy_tag_o);

  // R7
  no_relaunch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_valid_o |=> !(comp_valid_o && comp_tag_o == $past(comp_tag_o)));
endmodule

bind mq_dispatcher cqd_chk #(.MAX_COMPUTE(MAX_COMPUTE), .TW(TW)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .comp_valid_o    (comp_valid_o),
  .comp_tag_o      (comp_tag_o),
  .copy_valid_o    (copy_valid_o),
  .copy_tag_o      (copy_tag_o),
  .copy_dir_o      (copy_dir_o),
  .comp_done_i     (comp_done_i),
  .copy_done_i     (copy_done_i),
  .copy_done_tag_i (copy_done_tag_i)
);

// File: tb/test_mq_dispatcher.sv
module test_mq_dispatcher;
  localparam int NQ    = 8;
  localparam int DEPTH = 16;
  localparam int MAXC  = 4;
  localparam int NCMD  = 600;

  logic       clk = 0, rst_n = 0;
  logic       cmd_valid = 0, cmd_ready;
  logic [2:0] cmd_queue = 0;
  logic [1:0] cmd_kind = 0;
  logic       comp_valid, copy_valid, copy_dir;
  logic [3:0] comp_tag, copy_tag;
  logic       comp_done = 0, copy_done = 0;
  logic [3:0] comp_done_tag = 0, copy_done_tag = 0;

  always #5 clk = ~clk;

  mq_dispatcher #(.NUM_QUEUES(NQ), .PEND_DEPTH(DEPTH), .MAX_COMPUTE(MAXC)) i_mq_dispatcher (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_queue_i(cmd_queue), .cmd_kind_i(cmd_kind),
    .comp_valid_o(comp_valid), .comp_tag_o(comp_tag),
    .copy_valid_o(copy_valid), .copy_tag_o(copy_tag), .copy_dir_o(copy_dir),
    .comp_done_i(comp_done), .comp_done_tag_i(comp_done_tag),
    .copy_done_i(copy_done), .copy_done_tag_i(copy_done_tag));

  int n_chk = 0, n_fail = 0;
  int m_q[NCMD], m_k[NCMD], m_st[NCMD], m_tmr[NCMD], m_lat[NCMD];
  int iss = 0, ret = 0, comp_run = 0, h2d_run = 0, d2h_run = 0;
  int max_comp = 0, both_cnt = 0, dual_dir = 0, q0_launch = 0, launches = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // rules of R4, R7, R8, R5, R6 applied to the issue-ordered model
  task automatic model_pick(input bit cp, output bit f, output int idx);
    bit busyq[NQ];
    bit anyb, q0b, stop, cls, res;
    f = 0; idx = 0; anyb = 0; q0b = 0; stop = 0;
    for (int j = 0; j < NQ; j++) busyq[j] = 0;
    for (int i = ret; i < iss; i++) begin
      if (!stop) begin
        cls = cp ? (m_k[i] != 0) : (m_k[i] == 0);
        if (m_st[i] == 0 && cls) begin
          stop = 1; idx = i;
          res = (m_k[i] == 0) ? (comp_run < MAXC) : (m_k[i] >= 2 ? d2h_run == 0 : h2d_run == 0);
          f = res && !busyq[m_q[i]] && !q0b && !(m_q[i] == 0 && anyb);
        end
        if (m_st[i] != 2) begin
          busyq[m_q[i]] = 1; anyb = 1;
          if (m_q[i] == 0) q0b = 1;
        end
      end
    end
  endtask

  initial begin
    for (int n = 0; n < NCMD; n++) begin
      case (n / 150)
        0: begin m_k[n] = 0; m_q[n] = 1 + rnd() % 7; end
        1: begin m_k[n] = 1 + rnd() % 2; m_q[n] = rnd() % 8; end
        2: begin m_k[n] = rnd() % 3; m_q[n] = (rnd() % 3 == 0) ? 0 : rnd() % 8; end
        default: begin m_k[n] = rnd() % 4; m_q[n] = 1 + rnd() % 7; end
      endcase
      m_lat[n] = 1 + rnd() % 7;
      m_st[n] = 0; m_tmr[n] = 0;
    end
  end

  initial begin
    bit ef_c, ef_p, acc, rt;
    int ei_c, ei_p, cd, pd;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(!comp_valid && !copy_valid, "R1", comp_valid + copy_valid, 0);
    check(cmd_ready, "R1", cmd_ready, 1);
    rst_n = 1;
    @(negedge clk);
    check(!comp_valid && !copy_valid && cmd_ready, "R1", {comp_valid, copy_valid, cmd_ready}, 1);
    while (ret < NCMD) begin
      model_pick(0, ef_c, ei_c);
      model_pick(1, ef_p, ei_p);
      check(cmd_ready == ((iss - ret) < DEPTH), "R2", cmd_ready, (iss - ret) < DEPTH);
      check(comp_valid == ef_c, "R7 compute launch", comp_valid, ef_c);
      check(copy_valid == ef_p, "R7 copy launch", copy_valid, ef_p);
      if (ef_c && comp_valid) check(comp_tag == 4'(ei_c % DEPTH), "R3", comp_tag, ei_c % DEPTH);
      if (ef_p && copy_valid) begin
        check(copy_tag == 4'(ei_p % DEPTH), "R3", copy_tag, ei_p % DEPTH);
        check(copy_dir == (m_k[ei_p] >= 2), "R10", copy_dir, m_k[ei_p] >= 2);
      end
      if (ef_c && ef_p) both_cnt++;
      if (ef_c && m_q[ei_c] == 0) q0_launch++;
      if (ef_p && m_q[ei_p] == 0) q0_launch++;
      // inputs for the coming edge
      cmd_valid = (iss < NCMD) && ((iss / 150) == 2 || rnd() % 4 != 0);
      if (iss < NCMD) begin
        cmd_queue = 3'(m_q[iss]);
        cmd_kind  = 2'(m_k[iss]);
      end
      cd = -1; pd = -1;
      for (int i = ret; i < iss; i++) begin
        if (m_st[i] == 1 && m_tmr[i] == 0) begin
          if (m_k[i] == 0 && cd < 0) cd = i;
          if (m_k[i] != 0 && pd < 0) pd = i;
        end
      end
      comp_done = (cd >= 0); comp_done_tag = 4'((cd < 0 ? 0 : cd) % DEPTH);
      copy_done = (pd >= 0); copy_done_tag = 4'((pd < 0 ? 0 : pd) % DEPTH);
      // model of the coming edge
      rt  = (ret < iss) && m_st[ret] == 2;
      acc = cmd_valid && ((iss - ret) < DEPTH);
      for (int i = ret; i < iss; i++) if (m_st[i] == 1 && m_tmr[i] > 0) m_tmr[i]--;
      if (ef_c) begin m_st[ei_c] = 1; m_tmr[ei_c] = m_lat[ei_c]; comp_run++; launches++; end
      if (ef_p) begin
        m_st[ei_p] = 1; m_tmr[ei_p] = m_lat[ei_p]; launches++;
        if (m_k[ei_p] >= 2) d2h_run++; else h2d_run++;
      end
      if (cd >= 0) begin m_st[cd] = 2; comp_run--; end
      if (pd >= 0) begin
        m_st[pd] = 2;
        if (m_k[pd] >= 2) d2h_run--; else h2d_run--;
      end
      if (comp_run > max_comp) max_comp = comp_run;
      if (h2d_run == 1 && d2h_run == 1) dual_dir++;
      if (rt) ret++;
      if (acc) iss++;
      @(negedge clk);
    end
    check(max_comp == MAXC, "R5 limit reached", max_comp, MAXC);
    check(dual_dir > 0, "R6 both directions busy", dual_dir, 1);
    check(both_cnt > 0, "R9 dual launch", both_cnt, 1);
    check(q0_launch > 0, "R8 serial queue launched", q0_launch, 1);
    check(launches == NCMD, "R7 each launched once", launches, NCMD);
    check(cmd_ready && !comp_valid && !copy_valid, "R2 drained", cmd_ready, 1);
    finished = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", ret, NCMD);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule